// File: doc/BRIEF.md
# Maskable Three-Source Interrupt Status Unit

This block gathers three event strobes (a periodic tick, an alarm match and an end-of-update pulse) into sticky flags. It pairs each flag with its own enable bit and turns any enabled pending flag into an active-low, open-drain interrupt request. Software reads the status byte, which holds the summary request bit and the three flags. That read clears every flag. Each flag can be polled whether or not its enable is set.

The enable bits and a square-wave enable bit sit in a small control register inside the block. A chip-level active-low reset input clears that register and all three flags, and releases the request pin. The event generators, the alarm comparator and the time and memory state are outside the block, and the reset does not touch them. `irqDrvLow` is the pull-down enable for the open-drain pad. When it is low the pad floats.

Top module: `irq_status_unit`

## Requirements
- R1: An event strobe high at a rising clock edge sets its flag at that edge. The flag then stays set until a status read or a reset clears it.
- R2: A flag is set by its event whatever the state of its enable bit.
- R3: Status byte layout: bit 7 is the summary request bit; bits 6, 5 and 4 are the periodic, alarm and update flags; bits 3 to 0 always read 0.
- R4: The summary bit is the OR of the three flag-AND-enable pairs. While reset is high, `irqDrvLow` equals that OR.
- R5: A cycle with `statusRd` high presents the flags as they were before the read. All flags are cleared at the edge that ends that cycle.
- R6: An event that coincides with a status read leaves its flag set after that edge.
- R7: At an edge where `resetN` is low, all flags, the three enables and the square-wave enable are cleared, and a control write in that cycle is ignored. `irqDrvLow` is low whenever `resetN` is low.
- R8: A control write loads `ctrlWdata` at the next edge. The bit map is bit 3 periodic enable, bit 2 alarm enable, bit 1 update enable, bit 0 square-wave enable. `ctrlQ` reflects the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| resetN | input | 1 | Active-low reset pin; clears enables and flags |
| periodicEvt | input | 1 | Periodic tick strobe |
| alarmEvt | input | 1 | Alarm match strobe |
| updateEvt | input | 1 | End-of-update strobe |
| ctrlWe | input | 1 | Control register write strobe |
| ctrlWdata | input | 4 | Control write data (enables, square-wave enable) |
| statusRd | input | 1 | Status read strobe; clears the flags |
| ctrlQ | output | 4 | Control register contents |
| statusByte | output | 8 | Status byte: summary bit, three flags, zeros |
| irqDrvLow | output | 1 | High pulls the open-drain request line low |

## Verification
The assertions take every input as already synchronous to `clk`. A strobe counts once per cycle it is high, and reset is held for whole cycles. The stimulus drives every input on the falling edge, so nothing moves near the sampling edge. It holds each strobe for exactly the cycles it means to count. It also overlaps a read with a new event, and a control write with an active reset, so that both priorities get exercised.

// File: rtl/irq_status_pkg.sv
package irq_status_pkg;
  localparam int SRC_N    = 3;
  localparam int STATUS_W = 8;

  typedef struct packed {
    logic holdReset;
    logic clearFlags;
    logic loadCtrl;
  } ctrlStrobes_t;
endpackage

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import irq_status_pkg::*;
(
  input  logic         resetN,
  input  logic         statusRd,
  input  logic         ctrlWe,
  output ctrlStrobes_t strb
);
  // reset wins over any access made in the same cycle
  always_comb begin
    strb.holdReset  = !resetN;
    strb.clearFlags = resetN && statusRd;
    strb.loadCtrl   = resetN && ctrlWe;
  end
endmodule

// File: rtl/irq_status_dp.sv
module irq_status_dp
  import irq_status_pkg::*;
#(
  parameter int NSRC  = SRC_N,
  parameter int STW   = STATUS_W
) (
  input  logic            clk,
  input  ctrlStrobes_t    strb,
  input  logic [NSRC-1:0] evt,
  input  logic [NSRC:0]   ctrlWdata,
  output logic [NSRC:0]   ctrlQ,
  output logic            anyPending,
  output logic [STW-1:0]  statusByte
);
  localparam int PAD_W = STW - 1 - NSRC;

  logic [NSRC-1:0] flagQ;
  logic [NSRC-1:0] enQ;
  logic            sqwEnQ;

  // control register: enables in the upper bits, square-wave enable in bit 0
  always_ff @(posedge clk) begin
    if (strb.holdReset) begin
      enQ    <= '0;
      sqwEnQ <= 1'b0;
    end else if (strb.loadCtrl) begin
      enQ    <= ctrlWdata[NSRC:1];
      sqwEnQ <= ctrlWdata[0];
    end
  end

  // one sticky flag per source; a new event overrides the read clear
  for (genvar i = 0; i < NSRC; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (strb.holdReset)       flagQ[i] <= 1'b0;
      else if (evt[i])          flagQ[i] <= 1'b1;
      else if (strb.clearFlags) flagQ[i] <= 1'b0;
    end
  end

  always_comb begin
    anyPending = |(flagQ & enQ);
    ctrlQ      = {enQ, sqwEnQ};
    statusByte = {anyPending, flagQ, {PAD_W{1'b0}}};
  end
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
  import irq_status_pkg::*;
(
  input  logic       clk,
  input  logic       resetN,
  input  logic       periodicEvt,
  input  logic       alarmEvt,
  input  logic       updateEvt,
  input  logic       ctrlWe,
  input  logic [3:0] ctrlWdata,
  input  logic       statusRd,
  output logic [3:0] ctrlQ,
  output logic [7:0] statusByte,
  output logic       irqDrvLow
);
  ctrlStrobes_t strb;
  logic         anyPending;

  irq_status_ctrl u_ctrl (
    .resetN   (resetN),
    .statusRd (statusRd),
    .ctrlWe   (ctrlWe),
    .strb     (strb)
  );

  irq_status_dp #(.NSRC(SRC_N), .STW(STATUS_W)) u_dp (
    .clk        (clk),
    .strb       (strb),
    .evt        ({periodicEvt, alarmEvt, updateEvt}),
    .ctrlWdata  (ctrlWdata),
    .ctrlQ      (ctrlQ),
    .anyPending (anyPending),
    .statusByte (statusByte)
  );

  // pad pull-down enable; released while the reset pin is low
  assign irqDrvLow = resetN && anyPending;
endmodule

// File: rtl/irq_status_chk.sv
module irq_status_chk (
  input logic       clk,
  input logic       resetN,
  input logic       periodicEvt,
  input logic       alarmEvt,
  input logic       updateEvt,
  input logic       ctrlWe,
  input logic [3:0] ctrlWdata,
  input logic       statusRd,
  input logic [3:0] ctrlQ,
  input logic [7:0] statusByte,
  input logic       irqDrvLow
);
  // R1
  periodic_sets_chk: assert property (@(posedge clk) disable iff (!resetN)
    periodicEvt |=> statusByte[6]);
  // R1
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!resetN)
    (statusByte[5] && !statusRd) |=> statusByte[5]);
  // R3
  low_bits_zero_chk: assert property (@(posedge clk) disable iff (!resetN)
    statusByte[3:0] == 4'b0000);
  // R4
  irq_matches_pairs_chk: assert property (@(posedge clk) disable iff (!resetN)
    irqDrvLow == |(statusByte[6:4] & ctrlQ[3:1]));
  // R5
  read_clears_chk: assert property (@(posedge clk) disable iff (!resetN)
    (statusRd && !updateEvt) |=> !statusByte[4]);
  // R6
  read_keeps_new_chk: assert property (@(posedge clk) disable iff (!resetN)
    (statusRd && alarmEvt) |=> statusByte[5]);
  // R7
  reset_clears_chk: assert property (@(posedge clk)
    !resetN |=> (ctrlQ == 4'b0000 && statusByte[6:4] == 3'b000));
  // R8
  ctrl_load_chk: assert property (@(posedge clk) disable iff (!resetN)
    ctrlWe |=> ctrlQ == $past(ctrlWdata));
endmodule

bind irq_status_unit irq_status_chk chk_i (.*);

// File: tb/tb_irq_status_unit.sv
module tb_irq_status_unit;
  logic       clk = 1'b0;
  logic       resetN = 1'b0;
  logic       periodicEvt = 1'b0, alarmEvt = 1'b0, updateEvt = 1'b0;
  logic       ctrlWe = 1'b0;
  logic [3:0] ctrlWdata = 4'b0;
  logic       statusRd = 1'b0;
  logic [3:0] ctrlQ;
  logic [7:0] statusByte;
  logic       irqDrvLow;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  irq_status_unit dut (.*);

  typedef struct {
    logic [7:0] st;
    logic       irq;
    logic [3:0] ctrl;
    string      tag;
  } exp_t;
  exp_t sb[$];

  // reference state
  logic [2:0] mFlag = 3'b0;  // {periodic, alarm, update}
  logic [3:0] mCtrl = 4'b0;

  function automatic logic [7:0] mStatus();
    return {|(mFlag & mCtrl[3:1]), mFlag, 4'b0000};
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // drive one cycle at the falling edge and queue the outcome of the next edge
  task automatic step(input string tag, input logic rst, input logic [2:0] ev,
                      input logic rd, input logic we, input logic [3:0] wd);
    exp_t e;
    @(negedge clk);
    resetN = rst;
    {periodicEvt, alarmEvt, updateEvt} = ev;
    statusRd = rd; ctrlWe = we; ctrlWdata = wd;
    if (!rst) begin
      mFlag = 3'b0; mCtrl = 4'b0;
    end else begin
      if (we) mCtrl = wd;
      mFlag = (mFlag & ~{3{rd}}) | ev;
    end
    e.st = mStatus(); e.irq = rst && e.st[7]; e.ctrl = mCtrl; e.tag = tag;
    sb.push_back(e);
  endtask

  // monitor: compare after every rising edge
  initial begin
    forever begin
      @(posedge clk); #1;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        chk({e.tag, " status"}, {8'h0, statusByte}, {8'h0, e.st});
        chk({e.tag, " irq"},    {15'h0, irqDrvLow}, {15'h0, e.irq});
        chk({e.tag, " ctrl"},   {12'h0, ctrlQ},     {12'h0, e.ctrl});
      end
    end
  end

  initial begin
    #(200000 * 4);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R7: reset state
    repeat (3) step("R7 reset", 1'b0, 3'b000, 1'b0, 1'b0, 4'h0);
    // R8: enable all sources and square wave
    step("R8 write", 1'b1, 3'b000, 1'b0, 1'b1, 4'b1111);
    // R1/R3/R4: periodic event lands in bit 6 and raises the request
    step("R1 periodic", 1'b1, 3'b100, 1'b0, 1'b0, 4'h0);
    repeat (2) step("R1 sticky", 1'b1, 3'b000, 1'b0, 1'b0, 4'h0);
    // R5: read shows pre-clear value, then clears
    @(negedge clk); #1;
    chk("R5 pre-read view", {8'h0, statusByte}, {8'h0, 8'b1100_0000});
    step("R5 read", 1'b1, 3'b000, 1'b1, 1'b0, 4'h0);
    // R2: enables off, alarm still flagged, no request
    step("R8 write off", 1'b1, 3'b000, 1'b0, 1'b1, 4'b0000);
    step("R2 alarm masked", 1'b1, 3'b010, 1'b0, 1'b0, 4'h0);
    step("R2 hold", 1'b1, 3'b000, 1'b0, 1'b0, 4'h0);
    // R4: only the update enable set; update event raises request
    step("R4 update en", 1'b1, 3'b000, 1'b0, 1'b1, 4'b0010);
    step("R4 update evt", 1'b1, 3'b001, 1'b0, 1'b0, 4'h0);
    // R6: read coincides with a new alarm event
    step("R6 read+alarm", 1'b1, 3'b010, 1'b1, 1'b0, 4'h0);
    step("R6 after", 1'b1, 3'b000, 1'b0, 1'b0, 4'h0);
    // R4: alarm enable raises request from the already pending flag
    step("R4 alarm en", 1'b1, 3'b000, 1'b0, 1'b1, 4'b0100);
    step("R5 read all", 1'b1, 3'b000, 1'b1, 1'b0, 4'h0);
    // R3: all three flags together, status pattern
    step("R3 all events", 1'b1, 3'b111, 1'b0, 1'b1, 4'b1001);
    // R7: reset with a write attempt clears everything
    step("R7 reset+write", 1'b0, 3'b000, 1'b0, 1'b1, 4'b1111);
    step("R7 reset evt", 1'b0, 3'b111, 1'b0, 1'b0, 4'h0);
    step("R7 released", 1'b1, 3'b000, 1'b0, 1'b0, 4'h0);
    // R8: square-wave enable alone
    step("R8 sqw only", 1'b1, 3'b000, 1'b0, 1'b1, 4'b0001);
    step("R1 update masked", 1'b1, 3'b001, 1'b0, 1'b0, 4'h0);
    repeat (2) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule